// File: doc/BRIEF.md
# Image sensor line capture controller

This block takes one scan line from a parallel CMOS image sensor and keeps it in an on-chip line buffer that the host reads when the capture is finished. The host raises a request. The block then arms itself and waits for the start of a fresh line, meaning a rising line-valid while frame-valid is high. It stores each qualified pixel at the falling edge of the sensor pixel clock and raises a done acknowledge once the line has been stored.

The capture logic runs entirely in the pixel-clock domain. The request passes through a two-flop synchronizer into that domain, and the done flag passes through another two-flop synchronizer into the host clock domain. The host reads the buffer through a separate synchronous read port on its own clock. The pixel count and the short-line flag stay stable for as long as done is high.

A build parameter selects what each buffer entry holds: either the whole sample, or only the sample's upper eight bits.

Top module: `line_capture`

## Requirements
- R1: After reset, done_o and short_o are low, count_o is zero and rd_data_o is zero.
- R2: While the request is low, sensor lines write nothing. done_o stays low and count_o stays zero.
- R3: A pixel is stored only at a falling pixel-clock edge where frame_vld_i and line_vld_i are both high. A line sent while frame_vld_i is low is not captured.
- R4: The pixel sampled n-th in the captured line is stored at buffer address n, counting from 0. With rd_en_i high at a rising host-clock edge, rd_data_o shows the entry at rd_addr_i after that edge.
- R5: Once armed, capture starts at the first rising edge of line_vld_i that occurs while frame_vld_i is high. A line already in progress when the request arrives is skipped entirely.
- R6: Capture stops after LINE_LEN pixels. count_o then equals LINE_LEN, short_o is low, and any further pixels of the same line are not stored.
- R7: If either qualifier drops before LINE_LEN pixels have been stored, the capture ends. short_o goes high and count_o gives the number of pixels written.
- R8: done_o rises once the capture has ended and stays high while req_i stays high. Lines arriving during that time leave the buffer unchanged.
- R9: When req_i is dropped, done_o falls, count_o returns to zero and short_o clears. A later request re-arms the block.
- R10: With STORE_UPPER=0 each entry holds all PIX_W bits. With STORE_UPPER=1 each entry holds bits PIX_W-1 down to PIX_W-8 of the sample.
- R11: A read at an address of LINE_LEN or above returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk_i | input | 1 | Sensor pixel clock; capture logic uses its falling edge |
| host_clk_i | input | 1 | Host clock for the read port and the done synchronizer |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_vld_i | input | 1 | Sensor frame qualifier |
| line_vld_i | input | 1 | Sensor line qualifier |
| pix_i | input | PIX_W | Sensor pixel data |
| req_i | input | 1 | Host capture request (host domain) |
| done_o | output | 1 | Capture finished acknowledge (host domain) |
| short_o | output | 1 | Capture ended before LINE_LEN pixels |
| count_o | output | CNT_W | Number of pixels written |
| rd_en_i | input | 1 | Host read enable |
| rd_addr_i | input | CNT_W | Host read address |
| rd_data_o | output | STORE_W | Registered read data |

## Verification
There are two ways a capture can end: the pixel count reaches LINE_LEN, or a qualifier drops. For a line exactly LINE_LEN pixels long, both happen at neighbouring edges: the last write lands at the same edge where the count saturates, and line-valid falls at the next edge. The bench drives lines of every length from 1 to LINE_LEN+3. For each length it judges whether the short flag is set, whether the count saturates, and whether every stored entry matches. A line one pixel short has to set the flag, while an exact-length line and an over-long line must not. The bench also raises the request in the middle of a line, to provoke arming and a line already in flight landing in the same window; that line must be skipped and the next one captured.

// File: rtl/line_capture_pkg.sv
package line_capture_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAP  = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;

  localparam int unsigned NARROW_W = 8;
endpackage

// File: rtl/lc_sync.sv
module lc_sync #(
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;

  generate
    if (NEG_EDGE) begin : g_neg
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[0], d_i};
      end
    end else begin : g_pos
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[1];
endmodule

// File: rtl/lc_ctrl.sv
module lc_ctrl import line_capture_pkg::*; #(
  parameter int unsigned LINE_LEN = 1280,
  localparam int unsigned CNT_W = $clog2(LINE_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             fv_i,
  input  logic             lv_i,
  output logic             we_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             short_o
);
  cap_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_nxt;
  logic             short_q, short_d;
  logic             lv_q, lv_rise, last;

  assign lv_rise = lv_i & ~lv_q;
  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign last    = (cnt_nxt == CNT_W'(LINE_LEN));

  // all capture state moves on the falling pixel-clock edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      short_q <= 1'b0;
      lv_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      short_q <= short_d;
      lv_q    <= lv_i;
    end
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    short_d = short_q;
    we_o    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!req_i) begin
          st_d = ST_IDLE;
        end else if (lv_rise && fv_i) begin
          we_o  = 1'b1;
          cnt_d = cnt_nxt;
          st_d  = last ? ST_DONE : ST_CAP;
        end
      end
      ST_CAP: begin
        if (lv_i && fv_i) begin
          we_o  = 1'b1;
          cnt_d = cnt_nxt;
          if (last) st_d = ST_DONE;
        end else begin
          short_d = 1'b1;
          st_d    = ST_DONE;
        end
      end
      ST_DONE: begin
        if (!req_i) begin
          st_d    = ST_IDLE;
          cnt_d   = '0;
          short_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign cnt_o   = cnt_q;
  assign done_o  = (st_q == ST_DONE);
  assign short_o = short_q;
endmodule

// File: rtl/lc_line_ram.sv
module lc_line_ram #(
  parameter int unsigned DEPTH = 1280,
  parameter int unsigned DW    = 10,
  parameter int unsigned AW    = 11
) (
  input  logic          wr_clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(negedge wr_clk_i) begin
    if (we_i) mem[wr_addr_i[IW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      if (rd_addr_i < AW'(DEPTH)) rd_data_o <= mem[rd_addr_i[IW-1:0]];
      else                        rd_data_o <= '0;
    end
  end
endmodule

// File: rtl/line_capture.sv
module line_capture import line_capture_pkg::*; #(
  parameter int unsigned PIX_W       = 10,
  parameter int unsigned LINE_LEN    = 1280,
  parameter bit          STORE_UPPER = 1'b0,
  localparam int unsigned STORE_W = STORE_UPPER ? NARROW_W : PIX_W,
  localparam int unsigned CNT_W   = $clog2(LINE_LEN + 1)
) (
  input  logic               pix_clk_i,
  input  logic               host_clk_i,
  input  logic               rst_ni,
  input  logic               frame_vld_i,
  input  logic               line_vld_i,
  input  logic [PIX_W-1:0]   pix_i,
  input  logic               req_i,
  output logic               done_o,
  output logic               short_o,
  output logic [CNT_W-1:0]   count_o,
  input  logic               rd_en_i,
  input  logic [CNT_W-1:0]   rd_addr_i,
  output logic [STORE_W-1:0] rd_data_o
);
  logic               req_s;
  logic               wr_en;
  logic [CNT_W-1:0]   wr_cnt;
  logic               done_p;
  logic               short_p;
  logic [STORE_W-1:0] wr_data;

  lc_sync #(.NEG_EDGE(1'b1)) u_req_sync (
    .clk_i (pix_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  lc_ctrl #(.LINE_LEN(LINE_LEN)) u_ctrl (
    .clk_i  (pix_clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_s),
    .fv_i   (frame_vld_i),
    .lv_i   (line_vld_i),
    .we_o   (wr_en),
    .cnt_o  (wr_cnt),
    .done_o (done_p),
    .short_o(short_p)
  );

  generate
    if (STORE_UPPER) begin : g_upper
      assign wr_data = pix_i[PIX_W-1 -: STORE_W];
    end else begin : g_full
      assign wr_data = pix_i;
    end
  endgenerate

  lc_line_ram #(.DEPTH(LINE_LEN), .DW(STORE_W), .AW(CNT_W)) u_ram (
    .wr_clk_i (pix_clk_i),
    .we_i     (wr_en),
    .wr_addr_i(wr_cnt),
    .wr_data_i(wr_data),
    .rd_clk_i (host_clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o)
  );

  lc_sync #(.NEG_EDGE(1'b0)) u_done_sync (
    .clk_i (host_clk_i),
    .rst_ni(rst_ni),
    .d_i   (done_p),
    .q_o   (done_o)
  );

  // quasi-static while done is high
  assign short_o = short_p;
  assign count_o = wr_cnt;
endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
  parameter int unsigned LINE_LEN = 1280,
  parameter int unsigned CNT_W    = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fv_i,
  input logic             lv_i,
  input logic             req_i,
  input logic             we_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             done_i,
  input logic             short_i
);
  logic lv_prev;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lv_prev <= 1'b0;
    else         lv_prev <= lv_i;
  end

  p_write_qualified_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    we_i |-> (fv_i && lv_i));

  p_start_on_rise_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (we_i && cnt_i == '0) |-> (lv_i && !lv_prev));

  p_count_step_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    we_i |=> (cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

  p_count_bound_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    we_i |-> (cnt_i < CNT_W'(LINE_LEN)));

  p_short_count_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (done_i && short_i) |-> (cnt_i < CNT_W'(LINE_LEN)));

  p_full_not_short_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (done_i && cnt_i == CNT_W'(LINE_LEN)) |-> !short_i);

  p_done_hold_r8: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (done_i && req_i) |=> (done_i && !we_i));

  p_release_clear_r9: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (done_i && !req_i) |=> (!done_i && cnt_i == '0 && !short_i));
endmodule

bind line_capture lc_checker #(.LINE_LEN(LINE_LEN), .CNT_W(CNT_W)) u_chk (
  .clk_i  (pix_clk_i),
  .rst_ni (rst_ni),
  .fv_i   (frame_vld_i),
  .lv_i   (line_vld_i),
  .req_i  (req_s),
  .we_i   (wr_en),
  .cnt_i  (wr_cnt),
  .done_i (done_p),
  .short_i(short_p)
);

// File: tb/line_capture_test.sv
module line_capture_test;
  localparam int CLK_PERIOD  = 10;
  localparam int HOST_PERIOD = 14;
  localparam int PIX_W       = 10;
  localparam int LINE_LEN    = 16;
  localparam int CNT_W       = $clog2(LINE_LEN + 1);

  logic             pix_clk = 1'b0;
  logic             host_clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fv = 1'b0;
  logic             lv = 1'b0;
  logic [PIX_W-1:0] pix = '0;
  logic             req = 1'b0;
  logic             rd_en = 1'b0;
  logic [CNT_W-1:0] rd_addr = '0;

  logic             done, short_f, done8, short8;
  logic [CNT_W-1:0] count, count8;
  logic [PIX_W-1:0] rd_data;
  logic [7:0]       rd_data8;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) pix_clk = ~pix_clk;
  always #(HOST_PERIOD / 2) host_clk = ~host_clk;

  line_capture #(.PIX_W(PIX_W), .LINE_LEN(LINE_LEN), .STORE_UPPER(1'b0)) uut (
    .pix_clk_i(pix_clk), .host_clk_i(host_clk), .rst_ni(rst_n),
    .frame_vld_i(fv), .line_vld_i(lv), .pix_i(pix), .req_i(req),
    .done_o(done), .short_o(short_f), .count_o(count),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  line_capture #(.PIX_W(PIX_W), .LINE_LEN(LINE_LEN), .STORE_UPPER(1'b1)) uut8 (
    .pix_clk_i(pix_clk), .host_clk_i(host_clk), .rst_ni(rst_n),
    .frame_vld_i(fv), .line_vld_i(lv), .pix_i(pix), .req_i(req),
    .done_o(done8), .short_o(short8), .count_o(count8),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data8)
  );

  function automatic logic [PIX_W-1:0] pixv(int s, int i);
    return PIX_W'((s * 97 + i * 29 + 3) % 1024);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_line(int n, int seed);
    for (int i = 0; i < n; i++) begin
      @(posedge pix_clk);
      lv  <= 1'b1;
      pix <= pixv(seed, i);
    end
    @(posedge pix_clk);
    lv  <= 1'b0;
    pix <= '0;
    repeat (4) @(posedge pix_clk);
  endtask

  task automatic wait_done(string tag);
    int k = 0;
    while (!(done && done8) && k < 400) begin
      @(negedge host_clk);
      k++;
    end
    chk(tag, int'(done), 1);
    chk(tag, int'(done8), 1);
  endtask

  task automatic readback(int n, int seed, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge host_clk);
      rd_en   = 1'b1;
      rd_addr = CNT_W'(i);
      @(negedge host_clk);
      chk(tag, int'(rd_data), int'(pixv(seed, i)));
      chk({tag, " R10"}, int'(rd_data8), int'(pixv(seed, i) >> 2));
    end
    @(negedge host_clk);
    rd_en = 1'b0;
  endtask

  task automatic arm;
    @(negedge host_clk);
    req = 1'b1;
    repeat (6) @(posedge pix_clk);
  endtask

  task automatic release_req;
    @(negedge host_clk);
    req = 1'b0;
    repeat (12) @(negedge host_clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge host_clk);
    rst_n = 1'b1;
    @(negedge host_clk);
    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 short", int'(short_f), 0);
    chk("R1 count", int'(count), 0);
    chk("R1 rd_data", int'(rd_data), 0);

    // R2 lines without a request
    fv = 1'b1;
    send_line(LINE_LEN, 1);
    repeat (10) @(negedge host_clk);
    chk("R2 done", int'(done), 0);
    chk("R2 count", int'(count), 0);

    // R4/R6 normal full-line capture
    arm();
    send_line(LINE_LEN, 2);
    wait_done("R8 done rise");
    chk("R6 count", int'(count), LINE_LEN);
    chk("R6 short", int'(short_f), 0);
    chk("R10 count8", int'(count8), LINE_LEN);
    readback(LINE_LEN, 2, "R4 data");

    // R8 further lines ignored while done held
    send_line(LINE_LEN, 3);
    @(negedge host_clk);
    chk("R8 done held", int'(done), 1);
    readback(LINE_LEN, 2, "R8 no overwrite");

    // R11 out-of-range read
    @(negedge host_clk);
    rd_en = 1'b1;
    rd_addr = CNT_W'(LINE_LEN + 4);
    @(negedge host_clk);
    chk("R11 rd_data", int'(rd_data), 0);
    chk("R11 rd_data8", int'(rd_data8), 0);
    rd_en = 1'b0;

    // R9 release
    release_req();
    chk("R9 done", int'(done), 0);
    chk("R9 count", int'(count), 0);
    chk("R9 short", int'(short_f), 0);

    // R5 request arrives mid-line: that line skipped
    fork
      send_line(LINE_LEN, 4);
      begin
        repeat (3) @(posedge pix_clk);
        @(negedge host_clk);
        req = 1'b1;
      end
    join
    chk("R5 not done midline", int'(done), 0);
    send_line(LINE_LEN, 5);
    wait_done("R5 done");
    chk("R5 count", int'(count), LINE_LEN);
    readback(LINE_LEN, 5, "R5 data");
    release_req();

    // R3 line with frame-valid low ignored
    fv = 1'b0;
    arm();
    send_line(LINE_LEN, 6);
    repeat (6) @(negedge host_clk);
    chk("R3 done", int'(done), 0);
    chk("R3 count", int'(count), 0);
    fv = 1'b1;
    send_line(LINE_LEN, 7);
    wait_done("R3 done");
    readback(LINE_LEN, 7, "R3 data");
    release_req();

    // R7 frame-valid drop ends the capture
    arm();
    for (int i = 0; i < 6; i++) begin
      @(posedge pix_clk);
      lv  <= 1'b1;
      pix <= pixv(8, i);
    end
    @(posedge pix_clk);
    fv <= 1'b0;
    pix <= pixv(8, 6);
    repeat (3) @(posedge pix_clk);
    lv <= 1'b0;
    @(posedge pix_clk);
    fv <= 1'b1;
    wait_done("R7 fv drop done");
    chk("R7 fv drop short", int'(short_f), 1);
    chk("R7 fv drop count", int'(count), 6);
    readback(6, 8, "R7 fv drop data");
    release_req();

    // R6/R7 sweep of line lengths around the boundary
    for (int n = 1; n <= LINE_LEN + 3; n++) begin
      int exp_n;
      exp_n = (n < LINE_LEN) ? n : LINE_LEN;
      arm();
      send_line(n, 20 + n);
      wait_done("R8 sweep done");
      if (n < LINE_LEN) begin
        chk("R7 short", int'(short_f), 1);
        chk("R7 count", int'(count), exp_n);
        chk("R7 short8", int'(short8), 1);
      end else begin
        chk("R6 short", int'(short_f), 0);
        chk("R6 count", int'(count), exp_n);
      end
      readback(exp_n, 20 + n, "R4 sweep data");
      release_req();
      chk("R9 sweep count", int'(count), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule